// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a sticky record of every reset cause seen since software last looked. Seven causes are tracked: power-up, a low sensed on the shared reset pin, a watchdog timeout, an illegal opcode, an illegal address, a forced entry into monitor mode and a low supply voltage. Each cause input is sampled on the rising clock edge and only its rising edge counts. The causes are gathered into one read-only status byte. A bus read at the register's byte address returns the byte, and the same read wipes all the flags. Flags from different causes pile up until that read, so software can see several causes at once.

The block also drives the shared reset pin. An internal cause, or power-up itself, pulls the pin low for a programmable minimum time, but only when the pin is configured for reset use. Because the block senses the same pin it drives, it ignores a low that it causes itself. Only a low that comes from outside sets the pin flag.

Top module: `rstcause_top`

## Requirements
- R1: While `porN` is low and right after it rises, `statusByte` reads 8'h80: the power-up flag (bit 7) is set and every other bit is 0.
- R2: A rising edge on a cause input sets its bit one clock later: bit 6 for the pin low, bit 5 for the watchdog, bit 4 for the illegal opcode, bit 3 for the illegal address, bit 2 for the monitor entry and bit 1 for the low voltage.
- R3: Bit 0 of `statusByte` reads 0 at all times.
- R4: Flags from different causes accumulate without a read, so any mix of bits 6..1 can be set together.
- R5: A cycle with `busRead` high and `busAddr` equal to 16'hFE01 presents the unchanged byte in that cycle, and the byte reads 8'h00 from the next cycle on.
- R6: A cause edge that arrives in the same cycle as a clearing read leaves its flag set after the read.
- R7: A read strobe at any other address, or no read strobe, leaves the flags unchanged.
- R8: A cause input held high sets its flag once. After a clearing read the flag stays 0 until the input falls and rises again.
- R9: With `pinResetMode` high, an internal cause edge (bits 5..1) holds `pinPullLow` high for exactly HOLD_CYC cycles (32 by default). With `pinResetMode` low, `pinPullLow` stays low.
- R10: A low sensed on the pin while the block drives it, or in the cycle after the block releases it, does not set bit 6.
- R11: While `porN` is low and `pinResetMode` is high, `pinPullLow` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-up reset, active low, asynchronous |
| extPinLow | input | 1 | Low level sensed on the shared reset pin (1 = low) |
| wdogTimeout | input | 1 | Watchdog timeout request |
| illegalOp | input | 1 | Illegal opcode request |
| illegalAddr | input | 1 | Illegal address fetch request |
| monitorEntry | input | 1 | Forced monitor-mode entry request |
| lowVoltage | input | 1 | Low supply voltage request |
| busRead | input | 1 | Bus read strobe |
| busAddr | input | 16 | Bus byte address |
| pinResetMode | input | 1 | 1 = shared pin is configured for reset use |
| statusByte | output | 8 | Reset cause byte (read data) |
| pinPullLow | output | 1 | Enable that pulls the shared pin low |

## Verification
The assertions assume that cause inputs and bus signals change only between clock edges. They also assume that the pin sense follows the block's own pull-low with no more than one cycle of delay. The bench changes every input on the falling edge. It feeds the pin sense from its own external request ORed with `pinPullLow`, so any self-caused low falls inside the masked window. The sweep over all 63 cause combinations runs with the pin mode off, so no drive window from an earlier step can hide a pin edge.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int unsigned NUM_CAUSE = 6;       // bits 6..1 of the status byte
  localparam int unsigned PIN_BIT   = 6;
  localparam logic [15:0] DEF_ADDR  = 16'hFE01;

  typedef struct packed {
    logic       clearAll;   // clearing read this cycle
    logic [7:0] setMask;    // flag bits to set this cycle
  } flagStrobe_t;
endpackage

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 32,
  parameter logic [15:0] REG_ADDR = DEF_ADDR
) (
  input  logic                 clk,
  input  logic                 porN,
  input  logic [NUM_CAUSE-1:0] evtIn,        // [5]=pin, [4]=wdog .. [0]=low voltage
  input  logic                 busRead,
  input  logic [15:0]          busAddr,
  input  logic                 pinResetMode,
  output flagStrobe_t          strb,
  output logic                 pinPullLow
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [NUM_CAUSE-1:0] evtPrev;
  logic [NUM_CAUSE-1:0] evtRise;
  logic [CW-1:0]        holdCnt;
  logic                 pullLast;
  logic                 maskExt;
  logic                 intRise;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) evtPrev <= '0;
    else       evtPrev <= evtIn;
  end

  assign evtRise = evtIn & ~evtPrev;
  assign intRise = |evtRise[NUM_CAUSE-2:0];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)        holdCnt <= CW'(HOLD_CYC);
    else if (intRise) holdCnt <= CW'(HOLD_CYC);
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign pinPullLow = pinResetMode & ((holdCnt != '0) | ~porN);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pullLast <= 1'b0;
    else       pullLast <= pinPullLow;
  end

  assign maskExt = pinPullLow | pullLast;

  always_comb begin
    strb.clearAll = busRead && (busAddr == REG_ADDR);
    strb.setMask  = '0;
    for (int i = 0; i < int'(NUM_CAUSE) - 1; i++)
      strb.setMask[i+1] = evtRise[i];
    strb.setMask[PIN_BIT] = evtRise[NUM_CAUSE-1] & ~maskExt;
  end

  // R9
  hold_load_chk: assert property (@(posedge clk) disable iff (!porN)
    intRise |=> (holdCnt == CW'(HOLD_CYC)));

  // R10
  ext_mask_chk: assert property (@(posedge clk) disable iff (!porN)
    pinPullLow |-> !strb.setMask[PIN_BIT]);

  // R9
  mode_gate_chk: assert property (@(posedge clk) disable iff (!porN)
    !pinResetMode |-> !pinPullLow);
endmodule

// File: rtl/rstcause_dp.sv
module rstcause_dp
  import rstcause_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  flagStrobe_t strb,
  output logic [7:0]  statusByte
);
  logic [7:1] flags;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) flags <= 7'b1000000;
    else       flags <= (strb.clearAll ? 7'b0 : flags) | strb.setMask[7:1];
  end

  assign statusByte = {flags, 1'b0};

  // R4 R6
  set_keep_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.setMask[7:1] != '0) |=> ((flags & $past(strb.setMask[7:1])) == $past(strb.setMask[7:1])));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!porN)
    (strb.clearAll && strb.setMask[7:1] == '0) |=> (flags == '0));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!porN)
    (!strb.clearAll && strb.setMask[7:1] == '0) |=> $stable(flags));
endmodule

// File: rtl/rstcause_top.sv
module rstcause_top
  import rstcause_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 32,
  parameter logic [15:0] REG_ADDR = DEF_ADDR
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        extPinLow,
  input  logic        wdogTimeout,
  input  logic        illegalOp,
  input  logic        illegalAddr,
  input  logic        monitorEntry,
  input  logic        lowVoltage,
  input  logic        busRead,
  input  logic [15:0] busAddr,
  input  logic        pinResetMode,
  output logic [7:0]  statusByte,
  output logic        pinPullLow
);
  flagStrobe_t          strb;
  logic [NUM_CAUSE-1:0] evtIn;

  assign evtIn = {extPinLow, wdogTimeout, illegalOp, illegalAddr, monitorEntry, lowVoltage};

  rstcause_ctrl #(.HOLD_CYC(HOLD_CYC), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .porN(porN), .evtIn(evtIn), .busRead(busRead), .busAddr(busAddr),
    .pinResetMode(pinResetMode), .strb(strb), .pinPullLow(pinPullLow)
  );

  rstcause_dp u_dp (
    .clk(clk), .porN(porN), .strb(strb), .statusByte(statusByte)
  );
endmodule

// File: tb/rstcause_top_tb.sv
module rstcause_top_tb;
  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        benchExt = 1'b0;
  logic [4:0]  intEvt = '0;     // [4]=wdog [3]=ilop [2]=ilad [1]=mon [0]=lv
  logic        busRead = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        pinResetMode = 1'b1;
  logic [7:0]  statusByte;
  logic        pinPullLow;
  logic        extPinLow;
  int          nRun = 0;
  int          nFail = 0;

  always #10 clk = ~clk;   // 50 MHz

  assign extPinLow = benchExt | pinPullLow;

  rstcause_top u_dut (
    .clk(clk), .porN(porN), .extPinLow(extPinLow),
    .wdogTimeout(intEvt[4]), .illegalOp(intEvt[3]), .illegalAddr(intEvt[2]),
    .monitorEntry(intEvt[1]), .lowVoltage(intEvt[0]),
    .busRead(busRead), .busAddr(busAddr), .pinResetMode(pinResetMode),
    .statusByte(statusByte), .pinPullLow(pinPullLow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clearRead(input string req, input logic [7:0] exp);
    busRead = 1'b1; busAddr = 16'hFE01;
    #1;
    check(req, statusByte, exp);
    step();
    busRead = 1'b0;
    #1;
    check(req, statusByte, 8'h00);
  endtask

  initial begin
    int cnt;
    // R1 R11: values during power-up reset
    step();
    check("R1", statusByte, 8'h80);
    check("R11", {7'b0, pinPullLow}, 8'h01);
    porN = 1'b1;
    step();
    check("R1", statusByte, 8'h80);
    check("R3", {7'b0, statusByte[0]}, 8'h00);
    // R10: loopback low during the power-up drive must not set the pin flag
    repeat (40) step();
    check("R10", statusByte, 8'h80);
    // R7: wrong address and missing strobe leave flags alone
    busRead = 1'b1; busAddr = 16'hFE00;
    step();
    busRead = 1'b0; busAddr = 16'hFE01;
    step();
    check("R7", statusByte, 8'h80);
    clearRead("R5", 8'h80);

    // R2 R4 R5: sweep every cause combination with the pin mode off
    pinResetMode = 1'b0;
    for (int c = 1; c < 64; c++) begin
      benchExt = c[5];
      intEvt   = c[4:0];
      step();
      benchExt = 1'b0; intEvt = '0;
      step();
      check("R2/R4", statusByte, 8'(c << 1));
      check("R3", {7'b0, statusByte[0]}, 8'h00);
      clearRead("R5", 8'(c << 1));
    end

    // R6: cause edge in the same cycle as the clearing read
    intEvt[2] = 1'b1; step(); intEvt[2] = 1'b0; step();
    busRead = 1'b1; intEvt[4] = 1'b1;
    #1;
    check("R5", statusByte, 8'h08);
    step();
    busRead = 1'b0; intEvt[4] = 1'b0;
    step();
    check("R6", statusByte, 8'h20);
    clearRead("R5", 8'h20);

    // R8: held level sets once only
    intEvt[0] = 1'b1;
    step(); step();
    check("R8", statusByte, 8'h02);
    clearRead("R8", 8'h02);
    repeat (5) step();
    check("R8", statusByte, 8'h00);
    intEvt[0] = 1'b0; step();
    intEvt[0] = 1'b1; step();
    intEvt[0] = 1'b0; step();
    check("R8", statusByte, 8'h02);
    clearRead("R5", 8'h02);

    // R9: mode off never drives
    cnt = 0;
    intEvt[1] = 1'b1; step(); intEvt[1] = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (pinPullLow) cnt++;
      step();
    end
    check("R9", 8'(cnt), 8'd0);
    clearRead("R5", 8'h04);

    // R9 R10: mode on, drive lasts 32 cycles, loopback not flagged
    pinResetMode = 1'b1;
    cnt = 0;
    intEvt[4] = 1'b1; step(); intEvt[4] = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (pinPullLow) cnt++;
      step();
    end
    check("R9", 8'(cnt), 8'd32);
    check("R10", statusByte, 8'h20);
    clearRead("R5", 8'h20);

    // R2: external low while idle is flagged, no drive started
    benchExt = 1'b1; step(); benchExt = 1'b0; step();
    check("R2", statusByte, 8'h40);
    check("R9", {7'b0, pinPullLow}, 8'h00);
    clearRead("R5", 8'h40);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule